// File: doc/BRIEF.md
# Repeat Cycle Sequencer with Q Retry

The block lets a host run the same bus command over and over by touching a single "repeat" register address. It does not need to reload the command each time. A load of the function code opens a sequence and latches the access width, 8 or 16 bits. After that, each host read of the repeat address returns the data that the previous bus cycle fetched. Each host write of the repeat address places data into the low and middle byte registers. Once a full word has moved, the sequencer starts the next bus cycle by issuing the held command again.

In 8-bit mode a word takes two byte accesses, low byte first. In 16-bit mode one access moves the whole word.

An optional retry mode applies to read cycles only. After each read cycle the sequencer samples the Q response. While Q is 0 it issues the same cycle again. It stops when Q is 1, or when a fail timer reaches its limit and sets a fail flag. The limit is 12 µs of a 10 MHz reference, which is 120 clocks.

The bus cycle generator sits outside the block. It is reached through a start pulse and a done pulse. While a cycle is in flight, host accesses to the repeat address are held off by a ready signal.

Top module: `rpt_seq`

## Requirements
- R1: After reset, acc_ready is 1; cyc_start, fail, q_stat and x_stat are 0; acc_rdata is 0.
- R2: In 16-bit mode, an accepted read at address 12 returns {middle, low} on acc_rdata and pulses cyc_start for one cycle. Both appear at the accepting edge. The first such read after fc_load returns 0, because fc_load clears both byte registers. Each later read returns the word captured from the last completed read cycle.
- R3: In 8-bit mode, the first repeat read returns the low byte in bits 7:0 with bits 15:8 zero, and starts no cycle. The second returns the middle byte the same way and pulses cyc_start.
- R4: In 16-bit mode, an accepted write at address 12 loads acc_wdata[7:0] into the low byte and acc_wdata[15:8] into the middle byte. cyc_wdata then shows {middle, low}, and cyc_start pulses.
- R5: In 8-bit mode, the first repeat write loads acc_wdata[7:0] into the low byte and starts no cycle. The second write loads acc_wdata[7:0] into the middle byte and pulses cyc_start.
- R6: The width is sampled from mode16 (1 = 16-bit) only when fc_load is high. Changing mode16 later has no effect until the next fc_load.
- R7: acc_ready falls at the edge where a started cycle is accepted. It stays 0 until the edge after the cycle's final cyc_done. No repeat access is accepted while acc_ready is 0.
- R8: With qrep_en at 1, a read cycle that ends with cyc_q at 0 starts the same cycle again on the next edge. Retries continue until a cycle ends with cyc_q at 1.
- R9: fail rises once 120 clocks have elapsed with a cycle in flight since the last accepted repeat access. While fail is set, no further retry is started. The next accepted repeat access clears fail.
- R10: Retry never applies to write cycles. A write cycle that ends with cyc_q at 0 still returns the block to idle.
- R11: q_stat and x_stat load cyc_q and cyc_x on stat_rd, or at the end of a read cycle when qrep_en is 1. Otherwise they hold their value.
- R12: An access at any address other than 12 leaves the byte registers, acc_rdata and cyc_start untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_load | input | 1 | Function code load: opens a sequence, latches the width, clears the byte registers |
| mode16 | input | 1 | Access width, 1 = 16-bit, 0 = 8-bit |
| qrep_en | input | 1 | Enable Q retry on read cycles |
| stat_rd | input | 1 | Host reads the status register |
| acc_valid | input | 1 | Host access request, held until accepted |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Host register address |
| acc_wdata | input | 16 | Host write data |
| acc_ready | output | 1 | Sequencer idle; an access at address 12 is accepted at this edge |
| acc_rdata | output | 16 | Host read data for the repeat address |
| cyc_start | output | 1 | One-cycle pulse that reissues the held bus command |
| cyc_wdata | output | 16 | Write word {middle, low} for the bus cycle |
| cyc_done | input | 1 | Bus cycle finished |
| cyc_rdata | input | 16 | Read word from the bus cycle, valid with cyc_done |
| cyc_q | input | 1 | Q response of the bus cycle |
| cyc_x | input | 1 | X response of the bus cycle |
| q_stat | output | 1 | Latched Q status |
| x_stat | output | 1 | Latched X status |
| fail | output | 1 | Q retry timed out |

## Verification
Read data, cyc_start and the fall of acc_ready are all registered at the edge that accepts the access. The bench releases the request at the next falling edge and samples all three there.

A retry start comes one edge after cyc_done. The bench's bus model answers three falling edges after each start, so one retry takes four clocks. Because of that, the fail flag is expected about 120 clocks after acceptance, and idle a few clocks later. q_stat is checked at the falling edge after stat_rd. Start counts are taken only once the block has returned to idle, or after a wait of two clocks.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} rpt_state_t;
endpackage

// File: rtl/rpt_bytes.sv
// Byte register pair shared by reads and writes, plus the byte-phase logic.
module rpt_bytes #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fc_load,
  input  logic              mode16_in,
  input  logic              acc_fire,
  input  logic              acc_write,
  input  logic [WORD_W-1:0] acc_wdata,
  input  logic              cap,
  input  logic [WORD_W-1:0] cyc_rdata,
  output logic              trig,
  output logic [WORD_W-1:0] acc_rdata,
  output logic [WORD_W-1:0] word
);
  logic [BYTE_W-1:0] lo_q, mid_q;
  logic              phase_q;
  logic              wide_q;

  // A full word has moved: in 16-bit mode on every access, in 8-bit on the second.
  assign trig = acc_fire && (wide_q || phase_q);
  assign word = {mid_q, lo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q      <= '0;
      mid_q     <= '0;
      phase_q   <= 1'b0;
      wide_q    <= 1'b0;
      acc_rdata <= '0;
    end else if (fc_load) begin
      wide_q  <= mode16_in;
      phase_q <= 1'b0;
      lo_q    <= '0;
      mid_q   <= '0;
    end else if (acc_fire) begin
      if (wide_q) begin
        if (acc_write) {mid_q, lo_q} <= acc_wdata;
        else           acc_rdata     <= {mid_q, lo_q};
      end else begin
        phase_q <= ~phase_q;
        if (acc_write) begin
          if (phase_q) mid_q <= acc_wdata[BYTE_W-1:0];
          else         lo_q  <= acc_wdata[BYTE_W-1:0];
        end else begin
          acc_rdata <= {{BYTE_W{1'b0}}, (phase_q ? mid_q : lo_q)};
        end
      end
    end else if (cap) begin
      {mid_q, lo_q} <= cyc_rdata;
    end
  end
endmodule

// File: rtl/rpt_fail_timer.sv
// Counts busy clocks since the last repeat access; flags failure at the limit.
module rpt_fail_timer #(
  parameter int LIMIT = 120,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic fail
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      fail  <= 1'b0;
    end else if (run && !fail) begin
      if (cnt_q == CW'(LIMIT - 1)) fail <= 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rpt_ctrl.sv
// Cycle launcher, Q retry loop and status latches.
module rpt_ctrl
  import rpt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic trig_write,
  input  logic cyc_done,
  input  logic cyc_q,
  input  logic cyc_x,
  input  logic qrep_en,
  input  logic fail,
  input  logic stat_rd,
  output logic cyc_start,
  output logic idle,
  output logic cap,
  output logic run,
  output logic q_stat,
  output logic x_stat
);
  rpt_state_t st_q;
  logic       rd_cyc_q;
  logic       check;

  assign run   = (st_q == ST_RUN);
  assign cap   = run && cyc_done && rd_cyc_q;
  assign check = cap && qrep_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cyc_start <= 1'b0;
      idle      <= 1'b1;
      rd_cyc_q  <= 1'b0;
      q_stat    <= 1'b0;
      x_stat    <= 1'b0;
    end else begin
      cyc_start <= 1'b0;
      case (st_q)
        ST_IDLE: if (trig) begin
          st_q      <= ST_RUN;
          cyc_start <= 1'b1;
          idle      <= 1'b0;
          rd_cyc_q  <= !trig_write;
        end
        ST_RUN: if (cyc_done) begin
          if (check && !cyc_q && !fail) begin
            cyc_start <= 1'b1;
          end else begin
            st_q <= ST_IDLE;
            idle <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
      if (stat_rd || check) begin
        q_stat <= cyc_q;
        x_stat <= cyc_x;
      end
    end
  end
endmodule

// File: rtl/rpt_seq.sv
module rpt_seq #(
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int REPEAT_ADDR = 12,
  parameter int CLK_MHZ     = 10,
  parameter int FAIL_NS     = 12000,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int LIMIT  = CLK_MHZ * FAIL_NS / 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fc_load,
  input  logic              mode16,
  input  logic              qrep_en,
  input  logic              stat_rd,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [WORD_W-1:0] acc_wdata,
  output logic              acc_ready,
  output logic [WORD_W-1:0] acc_rdata,
  output logic              cyc_start,
  output logic [WORD_W-1:0] cyc_wdata,
  input  logic              cyc_done,
  input  logic [WORD_W-1:0] cyc_rdata,
  input  logic              cyc_q,
  input  logic              cyc_x,
  output logic              q_stat,
  output logic              x_stat,
  output logic              fail
);
  logic acc_fire, trig, cap, run;

  assign acc_fire = acc_valid && acc_ready && (acc_addr == ADDR_W'(REPEAT_ADDR));

  rpt_bytes #(.BYTE_W(BYTE_W)) u_bytes (
    .clk(clk), .rst(rst), .fc_load(fc_load), .mode16_in(mode16),
    .acc_fire(acc_fire), .acc_write(acc_write), .acc_wdata(acc_wdata),
    .cap(cap), .cyc_rdata(cyc_rdata), .trig(trig),
    .acc_rdata(acc_rdata), .word(cyc_wdata)
  );

  rpt_fail_timer #(.LIMIT(LIMIT)) u_timer (
    .clk(clk), .rst(rst), .clr(acc_fire), .run(run), .fail(fail)
  );

  rpt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .trig(trig), .trig_write(acc_write),
    .cyc_done(cyc_done), .cyc_q(cyc_q), .cyc_x(cyc_x), .qrep_en(qrep_en),
    .fail(fail), .stat_rd(stat_rd), .cyc_start(cyc_start), .idle(acc_ready),
    .cap(cap), .run(run), .q_stat(q_stat), .x_stat(x_stat)
  );
endmodule

// File: rtl/rpt_seq_chk.sv
module rpt_seq_chk #(
  parameter int ADDR_W      = 4,
  parameter int REPEAT_ADDR = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              stat_rd,
  input logic              cyc_done,
  input logic              cyc_start,
  input logic              q_stat,
  input logic              fail
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    cyc_start |-> !acc_ready); // R7

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!acc_ready && !cyc_done) |=> !acc_ready); // R7

  AST_RETRY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (!acc_ready && !cyc_done) |=> !cyc_start); // R8

  AST_FAIL_NO_RETRY: assert property (@(posedge clk) disable iff (rst)
    (fail && cyc_done && !acc_ready) |=> !cyc_start); // R9

  AST_FAIL_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_ready && acc_addr == ADDR_W'(REPEAT_ADDR)) |=> !fail); // R9

  AST_QSTAT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!stat_rd && !cyc_done) |=> $stable(q_stat)); // R11
endmodule

bind rpt_seq rpt_seq_chk #(.ADDR_W(ADDR_W), .REPEAT_ADDR(REPEAT_ADDR)) u_rpt_seq_chk (.*);

// File: tb/test_rpt_seq.sv
module test_rpt_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fc_load = 1'b0, mode16 = 1'b1, qrep_en = 1'b0, stat_rd = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [3:0]  acc_addr = '0;
  logic [15:0] acc_wdata = '0;
  logic        acc_ready, cyc_start, q_stat, x_stat, fail;
  logic [15:0] acc_rdata, cyc_wdata;
  logic        cyc_done = 1'b0, cyc_q = 1'b0, cyc_x = 1'b1;
  logic [15:0] cyc_rdata = '0;

  int n_chk = 0, n_bad = 0, n_start = 0, lat = 0, q_zero_left = 0;
  logic [15:0] next_word = 16'hA001, last_word = '0;

  always #4 clk = ~clk;

  rpt_seq i_rpt_seq (.*);

  always @(posedge clk) if (cyc_start) n_start <= n_start + 1;

  // Bus cycle model: done three falling edges after each start.
  always @(negedge clk) begin
    cyc_done = 1'b0;
    if (cyc_start) lat = 3;
    else if (lat > 0) begin
      lat = lat - 1;
      if (lat == 0) begin
        cyc_done  = 1'b1;
        cyc_rdata = next_word;
        last_word = next_word;
        next_word = next_word + 16'h0111;
        cyc_q     = (q_zero_left == 0);
        cyc_x     = ~cyc_q;
        if (q_zero_left > 0) q_zero_left = q_zero_left - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input [3:0] addr, input [15:0] wd);
    int guard = 0;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = addr; acc_wdata = wd;
    while (!acc_ready && guard < 1000) begin @(negedge clk); guard++; end
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while (!acc_ready && cycles < 1000) begin @(negedge clk); cycles++; end
  endtask

  task automatic load_fc(input bit m);
    @(negedge clk); fc_load = 1'b1; mode16 = m;
    @(negedge clk); fc_load = 1'b0;
  endtask

  task automatic t_reset;
    chk(acc_ready == 1'b1, "R1 ready", acc_ready, 1);
    chk(cyc_start == 1'b0 && fail == 1'b0, "R1 start/fail", {cyc_start, fail}, 0);
    chk(q_stat == 1'b0 && x_stat == 1'b0, "R1 status", {q_stat, x_stat}, 0);
    chk(acc_rdata == 16'h0, "R1 rdata", acc_rdata, 0);
  endtask

  task automatic t_rd16;
    int c, s0;
    qrep_en = 1'b0; q_zero_left = 0;
    load_fc(1'b1);
    s0 = n_start;
    access(1'b0, 4'd12, 16'h0);
    chk(acc_rdata == 16'h0, "R2 first read discarded", acc_rdata, 0);
    chk(cyc_start == 1'b1, "R2 start pulse", cyc_start, 1);
    chk(acc_ready == 1'b0, "R7 ready low", acc_ready, 0);
    access(1'b0, 4'd12, 16'h0);  // issued while busy: must wait for done
    chk(acc_rdata == last_word, "R7 stalled read gets first word", acc_rdata, last_word);
    wait_idle(c);
    chk(n_start - s0 == 2, "R2 one start per read", n_start - s0, 2);
    access(1'b0, 4'd12, 16'h0);
    chk(acc_rdata == last_word, "R2 word from last cycle", acc_rdata, last_word);
    wait_idle(c);
  endtask

  task automatic t_rd8;
    int c, s0;
    load_fc(1'b0);
    mode16 = 1'b1;               // R6: must not take effect
    s0 = n_start;
    access(1'b0, 4'd12, 16'h0);
    chk(cyc_start == 1'b0, "R6 mode held at 8-bit", cyc_start, 0);
    access(1'b0, 4'd12, 16'h0);
    chk(cyc_start == 1'b1, "R3 start after second byte", cyc_start, 1);
    wait_idle(c);
    access(1'b0, 4'd12, 16'h0);
    chk(acc_rdata == {8'h00, last_word[7:0]}, "R3 low byte", acc_rdata, {8'h00, last_word[7:0]});
    repeat (2) @(negedge clk);
    chk(n_start - s0 == 1, "R3 no start after low byte", n_start - s0, 1);
    access(1'b0, 4'd12, 16'h0);
    chk(acc_rdata == {8'h00, last_word[15:8]}, "R3 middle byte", acc_rdata, {8'h00, last_word[15:8]});
    chk(cyc_start == 1'b1, "R3 start after middle byte", cyc_start, 1);
    wait_idle(c);
  endtask

  task automatic t_wr16;
    int c, s0;
    load_fc(1'b1);
    qrep_en = 1'b1; q_zero_left = 1;
    s0 = n_start;
    access(1'b1, 4'd12, 16'hBEEF);
    chk(cyc_wdata == 16'hBEEF, "R4 word loaded", cyc_wdata, 16'hBEEF);
    chk(cyc_start == 1'b1, "R4 start", cyc_start, 1);
    wait_idle(c);
    repeat (6) @(negedge clk);
    chk(n_start - s0 == 1, "R10 no retry on write", n_start - s0, 1);
    qrep_en = 1'b0; q_zero_left = 0;
  endtask

  task automatic t_wr8;
    int c;
    load_fc(1'b0);
    access(1'b1, 4'd12, 16'hFF12);
    chk(cyc_start == 1'b0, "R5 no start after low byte", cyc_start, 0);
    chk(cyc_wdata == 16'h0012, "R5 low byte", cyc_wdata, 16'h0012);
    access(1'b1, 4'd12, 16'hEE34);
    chk(cyc_wdata == 16'h3412, "R5 middle byte", cyc_wdata, 16'h3412);
    chk(cyc_start == 1'b1, "R5 start after middle byte", cyc_start, 1);
    wait_idle(c);
  endtask

  task automatic t_qretry;
    int c, s0;
    load_fc(1'b1);
    qrep_en = 1'b1; q_zero_left = 2;
    s0 = n_start;
    access(1'b0, 4'd12, 16'h0);
    wait_idle(c);
    chk(n_start - s0 == 3, "R8 retries until Q", n_start - s0, 3);
    chk(q_stat == 1'b1, "R8 Q latched by sequencer", q_stat, 1);
    access(1'b0, 4'd12, 16'h0);
    chk(acc_rdata == last_word, "R8 data from final retry", acc_rdata, last_word);
    wait_idle(c);
    qrep_en = 1'b0; q_zero_left = 1;
    access(1'b0, 4'd12, 16'h0);
    wait_idle(c);
    chk(q_stat == 1'b1, "R11 Q held without status read", q_stat, 1);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk(q_stat == 1'b0 && x_stat == 1'b1, "R11 status read latches", {q_stat, x_stat}, 1);
    q_zero_left = 0;
  endtask

  task automatic t_fail;
    int c, s0;
    load_fc(1'b1);
    qrep_en = 1'b1; q_zero_left = 100000;
    access(1'b0, 4'd12, 16'h0);
    repeat (99) @(negedge clk);
    chk(fail == 1'b0, "R9 no fail before limit", fail, 0);
    wait_idle(c);
    c = c + 99;
    chk(fail == 1'b1, "R9 fail set", fail, 1);
    chk(c >= 120 && c <= 132, "R9 fail timing", c, 124);
    s0 = n_start;
    repeat (20) @(negedge clk);
    chk(n_start == s0, "R9 retries stopped", n_start - s0, 0);
    q_zero_left = 0;
    access(1'b0, 4'd12, 16'h0);
    chk(fail == 1'b0, "R9 fail cleared by access", fail, 0);
    wait_idle(c);
    qrep_en = 1'b0;
  endtask

  task automatic t_other;
    int s0;
    load_fc(1'b1);
    s0 = n_start;
    @(negedge clk); acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 4'd4; acc_wdata = 16'hFFFF;
    @(negedge clk); acc_write = 1'b0;
    @(negedge clk); acc_valid = 1'b0;
    @(negedge clk);
    chk(cyc_wdata == 16'h0 && n_start == s0, "R12 other address ignored", cyc_wdata, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_rd16;
    t_rd8;
    t_wr16;
    t_wr8;
    t_qretry;
    t_fail;
    t_other;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule